// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

The block adds two IEEE 754 binary32 operands and delivers a correctly rounded binary32 sum together with invalid, overflow, underflow and inexact flags. A caller presents both operands, a two-bit rounding mode and a valid strobe in one cycle. The registered result, its flags and a result strobe appear on the next clock edge. Subtraction is done by the caller, who inverts the sign bit of the second operand before presenting it.

Inside, each operand is classified and unpacked, and subnormal inputs are normalized. Operand pairs that involve NaNs, infinities or zeros are resolved by a fixed priority network. The remaining pairs go through a datapath that widens the significands by three low bits, aligns the smaller operand with a sticky-preserving right shift, adds or subtracts the magnitudes and renormalizes. Rounding, overflow saturation and packing come last.

Top module: `fp32_adder`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. Result and flags update only on such a cycle. Reset clears `valid_o`, `sum_o` and all flags to zero.
- R2: A signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) in `a_i` takes priority. Otherwise a signaling NaN in `b_i` is used. The result is that operand with fraction bit 22 set, and `invalid_o` is 1.
- R3: If neither operand is a signaling NaN, a quiet NaN (exponent all ones, fraction bit 22 set) is returned bit for bit. If both operands are quiet NaNs, `a_i` is returned. No flag is set.
- R4: Two infinities of equal sign return that infinity. Two of opposite sign return `DEFAULT_NAN` (default 0x7FC00000) with `invalid_o` set. An infinity plus any finite operand returns the infinity.
- R5: A zero plus a nonzero finite operand returns the nonzero operand unchanged. Two zeros of equal sign return `a_i`.
- R6: A sum that is exactly zero from operands of opposite sign (two opposite zeros, or exact cancellation) is +0 in modes 0, 1 and 2 and -0 in mode 3, with no flag set.
- R7: Subnormal operands contribute their exact value, so sums of subnormals are exact.
- R8: Mode 0 rounds to nearest with ties to the even significand. `inexact_o` is set whenever the discarded part of the exact sum is nonzero.
- R9: Mode 1 truncates toward zero, mode 2 rounds toward +infinity and mode 3 rounds toward -infinity.
- R10: If the rounded exponent exceeds the largest finite exponent, `overflow_o` and `inexact_o` are set. The result is an infinity in mode 0, in mode 2 for a positive sum and in mode 3 for a negative sum. Otherwise it is the largest finite magnitude 0x7F7FFFFF with the sum's sign.
- R11: A result below the normal range is denormalized before rounding. `underflow_o` is set only when such a result is also inexact, so exact subnormal sums leave it clear.
- R12: Bits shifted out during alignment are kept as sticky, so a small addend far below the other operand still sets `inexact_o` and moves directed rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are presented this cycle |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| rmode_i | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| sum_o | output | 32 | Rounded binary32 sum |
| invalid_o | output | 1 | Invalid operation |
| overflow_o | output | 1 | Rounded result overflowed |
| underflow_o | output | 1 | Tiny and inexact result |
| inexact_o | output | 1 | Result differs from the exact sum |

## Verification
The hardest cases to reach are the rounding boundaries, where the exact sum lies on or next to a halfway point between two representable values. Uniform random operands almost never land there, because their exponents are far apart. The stimulus therefore uses directed ties and near-ties built from 1.0 and 2^-24, and its random phase draws the second operand with an exponent a few steps from the first, sometimes with the opposite sign and a nearly equal fraction. That mix reaches carries out of the significand, deep cancellations and exact zeros. Every sum is compared with a reference model that forms the exact sum as a wide fixed-point integer and rounds it by remainder comparison.

// File: rtl/fp32_add_pkg.sv
package fp32_add_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int GRS_W    = 3;
  localparam int WRK_W    = SIG_W + GRS_W;
  localparam int WEXP_W   = EXP_W + 2;
  localparam int LZ_W     = $clog2(WRK_W + 1);
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;
  localparam int QBIT     = FRAC_W - 1;

  typedef logic signed [WEXP_W-1:0] wexp_t;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } fp_cls_e;

  typedef enum logic [1:0] {
    RM_RNE = 2'd0, RM_RTZ = 2'd1, RM_RUP = 2'd2, RM_RDN = 2'd3
  } rmode_e;

  // leading zero count over the working width
  function automatic logic [LZ_W-1:0] lzc(input logic [WRK_W-1:0] v);
    lzc = LZ_W'(WRK_W);
    for (int i = 0; i < WRK_W; i++) begin
      if (v[i]) lzc = LZ_W'(WRK_W - 1 - i);
    end
  endfunction

  // right shift, lost bits ORed into bit 0
  function automatic logic [WRK_W-1:0] shr_sticky(input logic [WRK_W-1:0] v,
                                                  input logic [LZ_W-1:0]  sh);
    logic [2*WRK_W-1:0] w;
    w = {v, {WRK_W{1'b0}}} >> sh;
    return {w[2*WRK_W-1:WRK_W+1], w[WRK_W] | (|w[WRK_W-1:0])};
  endfunction

  // clamp a non-negative shift distance to the working width
  function automatic logic [LZ_W-1:0] cap_shift(input wexp_t d);
    if (d > wexp_t'(WRK_W)) return LZ_W'(WRK_W);
    return d[LZ_W-1:0];
  endfunction
endpackage

// File: rtl/fp32_unpack.sv
module fp32_unpack
  import fp32_add_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fp_cls_e           cls_o,
  output logic              sign_o,
  output wexp_t             exp_o,
  output logic [SIG_W-1:0]  sig_o
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [LZ_W-1:0]   lz;

  assign e      = word_i[WORD_W-2 -: EXP_W];
  assign f      = word_i[FRAC_W-1:0];
  assign sign_o = word_i[WORD_W-1];
  assign lz     = lzc({1'b0, f, {GRS_W{1'b0}}});

  always_comb begin
    cls_o = CLS_NORM;
    exp_o = wexp_t'({2'b00, e});
    sig_o = {1'b1, f};
    if (e == '0) begin
      if (f == '0) begin
        cls_o = CLS_ZERO;
        sig_o = '0;
      end else begin
        cls_o = CLS_SUB;
        sig_o = {1'b0, f} << lz;
        exp_o = wexp_t'(1) - wexp_t'(lz);
      end
    end else if (e == EXP_W'(EXP_ALL1)) begin
      if (f == '0)      cls_o = CLS_INF;
      else if (f[QBIT]) cls_o = CLS_QNAN;
      else              cls_o = CLS_SNAN;
    end
  end
endmodule

// File: rtl/fp32_mag_core.sv
module fp32_mag_core
  import fp32_add_pkg::*;
(
  input  logic             x_sign_i,
  input  wexp_t            x_exp_i,
  input  logic [SIG_W-1:0] x_sig_i,
  input  logic             y_sign_i,
  input  wexp_t            y_exp_i,
  input  logic [SIG_W-1:0] y_sig_i,
  output logic             sign_o,
  output wexp_t            exp_o,
  output logic [WRK_W-1:0] sig_o,
  output logic             zero_o
);
  wexp_t            d, big_e;
  logic             x_big, x_ge;
  logic [LZ_W-1:0]  sh, nlz;
  logic [WRK_W-1:0] xw, yw, xa, ya, diff;
  logic [WRK_W:0]   sum;

  assign d     = x_exp_i - y_exp_i;
  assign x_big = (d >= 0);
  assign big_e = x_big ? x_exp_i : y_exp_i;
  assign sh    = cap_shift(x_big ? d : -d);
  assign xw    = {x_sig_i, {GRS_W{1'b0}}};
  assign yw    = {y_sig_i, {GRS_W{1'b0}}};
  assign xa    = x_big ? xw : shr_sticky(xw, sh);
  assign ya    = x_big ? shr_sticky(yw, sh) : yw;
  assign sum   = {1'b0, xa} + {1'b0, ya};
  assign x_ge  = (xa >= ya);
  assign diff  = x_ge ? (xa - ya) : (ya - xa);
  assign nlz   = lzc(diff);

  always_comb begin
    zero_o = 1'b0;
    if (x_sign_i == y_sign_i) begin
      sign_o = x_sign_i;
      if (sum[WRK_W]) begin
        sig_o = {sum[WRK_W:2], sum[1] | sum[0]};
        exp_o = big_e + wexp_t'(1);
      end else begin
        sig_o = sum[WRK_W-1:0];
        exp_o = big_e;
      end
    end else begin
      sign_o = x_ge ? x_sign_i : y_sign_i;
      zero_o = (diff == '0);
      sig_o  = diff << nlz;
      exp_o  = big_e - wexp_t'(nlz);
    end
  end
endmodule

// File: rtl/fp32_round_pack.sv
module fp32_round_pack
  import fp32_add_pkg::*;
(
  input  logic              sign_i,
  input  wexp_t             exp_i,
  input  logic [WRK_W-1:0]  sig_i,
  input  logic [1:0]        rmode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              inexact_o
);
  localparam wexp_t EXP_OVF = wexp_t'(EXP_ALL1);

  logic             tiny, lost, inc, to_inf;
  logic [WRK_W-1:0] m;
  logic [SIG_W:0]   mr;
  wexp_t            e_fin;
  logic [FRAC_W-1:0] frac;

  assign tiny = (exp_i < wexp_t'(1));
  assign m    = tiny ? shr_sticky(sig_i, cap_shift(wexp_t'(1) - exp_i)) : sig_i;
  assign lost = |m[GRS_W-1:0];

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_RNE:  inc = m[GRS_W-1] & (m[GRS_W-2] | m[0] | m[GRS_W]);
      RM_RTZ:  inc = 1'b0;
      RM_RUP:  inc = lost & ~sign_i;
      default: inc = lost & sign_i;
    endcase
  end

  assign mr = {1'b0, m[WRK_W-1:GRS_W]} + (SIG_W+1)'(inc);

  always_comb begin
    if (tiny) begin
      e_fin = mr[SIG_W-1] ? wexp_t'(1) : wexp_t'(0);
      frac  = mr[FRAC_W-1:0];
    end else if (mr[SIG_W]) begin
      e_fin = exp_i + wexp_t'(1);
      frac  = mr[FRAC_W:1];
    end else begin
      e_fin = exp_i;
      frac  = mr[FRAC_W-1:0];
    end
  end

  assign overflow_o  = ~tiny & (e_fin >= EXP_OVF);
  assign underflow_o = tiny & lost;
  assign inexact_o   = lost | overflow_o;
  assign to_inf      = (rmode_e'(rmode_i) == RM_RNE) ||
                       (rmode_e'(rmode_i) == RM_RUP && !sign_i) ||
                       (rmode_e'(rmode_i) == RM_RDN && sign_i);

  always_comb begin
    if (overflow_o) begin
      word_o = to_inf ? {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                      : {sign_i, EXP_W'(EXP_ALL1 - 1), {FRAC_W{1'b1}}};
    end else begin
      word_o = {sign_i, e_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
  import fp32_add_pkg::*;
#(
  parameter logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [1:0]        rmode_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] sum_o,
  output logic              invalid_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              inexact_o
);
  localparam int NUM_OPS = 2;
  localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << QBIT;

  logic [WORD_W-1:0] op_word [NUM_OPS];
  fp_cls_e           op_cls  [NUM_OPS];
  logic              op_sign [NUM_OPS];
  wexp_t             op_exp  [NUM_OPS];
  logic [SIG_W-1:0]  op_sig  [NUM_OPS];

  assign op_word[0] = a_i;
  assign op_word[1] = b_i;

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_unpack
    fp32_unpack i_unpack (
      .word_i (op_word[gi]),
      .cls_o  (op_cls[gi]),
      .sign_o (op_sign[gi]),
      .exp_o  (op_exp[gi]),
      .sig_o  (op_sig[gi])
    );
  end

  logic [WORD_W-1:0] zero_word;
  assign zero_word = {rmode_e'(rmode_i) == RM_RDN, {(WORD_W-1){1'b0}}};

  // fixed-priority resolution of non-arithmetic pairs
  logic              spc_hit, spc_inv;
  logic [WORD_W-1:0] spc_word;

  always_comb begin
    spc_hit  = 1'b1;
    spc_inv  = 1'b0;
    spc_word = '0;
    if (op_cls[0] == CLS_SNAN) begin
      spc_word = a_i | QUIET_MASK;
      spc_inv  = 1'b1;
    end else if (op_cls[1] == CLS_SNAN) begin
      spc_word = b_i | QUIET_MASK;
      spc_inv  = 1'b1;
    end else if (op_cls[0] == CLS_QNAN) begin
      spc_word = a_i;
    end else if (op_cls[1] == CLS_QNAN) begin
      spc_word = b_i;
    end else if (op_cls[0] == CLS_INF && op_cls[1] == CLS_INF) begin
      if (op_sign[0] == op_sign[1]) spc_word = a_i;
      else begin
        spc_word = DEFAULT_NAN;
        spc_inv  = 1'b1;
      end
    end else if (op_cls[0] == CLS_INF) begin
      spc_word = a_i;
    end else if (op_cls[1] == CLS_INF) begin
      spc_word = b_i;
    end else if (op_cls[0] == CLS_ZERO && op_cls[1] == CLS_ZERO) begin
      spc_word = (op_sign[0] == op_sign[1]) ? a_i : zero_word;
    end else if (op_cls[0] == CLS_ZERO) begin
      spc_word = b_i;
    end else if (op_cls[1] == CLS_ZERO) begin
      spc_word = a_i;
    end else begin
      spc_hit = 1'b0;
    end
  end

  logic             core_sign, core_zero;
  wexp_t            core_exp;
  logic [WRK_W-1:0] core_sig;

  fp32_mag_core i_core (
    .x_sign_i (op_sign[0]),
    .x_exp_i  (op_exp[0]),
    .x_sig_i  (op_sig[0]),
    .y_sign_i (op_sign[1]),
    .y_exp_i  (op_exp[1]),
    .y_sig_i  (op_sig[1]),
    .sign_o   (core_sign),
    .exp_o    (core_exp),
    .sig_o    (core_sig),
    .zero_o   (core_zero)
  );

  logic [WORD_W-1:0] rnd_word;
  logic              rnd_ovf, rnd_unf, rnd_inx;

  fp32_round_pack i_round (
    .sign_i      (core_sign),
    .exp_i       (core_exp),
    .sig_i       (core_sig),
    .rmode_i     (rmode_i),
    .word_o      (rnd_word),
    .overflow_o  (rnd_ovf),
    .underflow_o (rnd_unf),
    .inexact_o   (rnd_inx)
  );

  logic [WORD_W-1:0] res_word;
  logic              res_inv, res_ovf, res_unf, res_inx;

  always_comb begin
    res_word = rnd_word;
    res_inv  = 1'b0;
    res_ovf  = rnd_ovf;
    res_unf  = rnd_unf;
    res_inx  = rnd_inx;
    if (spc_hit || core_zero) begin
      res_word = spc_hit ? spc_word : zero_word;
      res_inv  = spc_hit & spc_inv;
      res_ovf  = 1'b0;
      res_unf  = 1'b0;
      res_inx  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      sum_o       <= '0;
      invalid_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o       <= res_word;
        invalid_o   <= res_inv;
        overflow_o  <= res_ovf;
        underflow_o <= res_unf;
        inexact_o   <= res_inx;
      end
    end
  end
endmodule

// File: rtl/fp32_adder_chk.sv
module fp32_adder_chk
  import fp32_add_pkg::*;
#(
  parameter logic [WORD_W-1:0] DEFAULT_NAN = 32'h7FC0_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [1:0]        rmode_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] sum_o,
  input logic              invalid_o,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic              inexact_o
);
  localparam logic [WORD_W-1:0] SIGN_MASK  = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << QBIT;

  logic a_top, b_top, a_snan, a_inf, b_inf;
  assign a_top  = (a_i[WORD_W-2 -: EXP_W] == EXP_W'(EXP_ALL1));
  assign b_top  = (b_i[WORD_W-2 -: EXP_W] == EXP_W'(EXP_ALL1));
  assign a_snan = a_top && (a_i[FRAC_W-1:0] != '0) && !a_i[QBIT];
  assign a_inf  = a_top && (a_i[FRAC_W-1:0] == '0);
  assign b_inf  = b_top && (b_i[FRAC_W-1:0] == '0);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_SNAN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_snan) |=> (invalid_o && sum_o == ($past(a_i) | QUIET_MASK))); // R2
  AST_INF_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_inf && b_inf && (a_i[WORD_W-1] != b_i[WORD_W-1]))
      |=> (invalid_o && sum_o == DEFAULT_NAN)); // R4
  AST_CANCEL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !a_top && (a_i == (b_i ^ SIGN_MASK)))
      |=> (sum_o == {$past(rmode_i) == 2'd3, {(WORD_W-1){1'b0}}} && !inexact_o)); // R6
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o); // R10
  AST_OVF_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o) |->
      (sum_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} ||
       sum_o[WORD_W-2:0] == {EXP_W'(EXP_ALL1 - 1), {FRAC_W{1'b1}}})); // R10
  AST_UNF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> inexact_o); // R11
endmodule

bind fp32_adder fp32_adder_chk #(.DEFAULT_NAN(DEFAULT_NAN)) i_fp32_adder_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .rmode_i     (rmode_i),
  .valid_o     (valid_o),
  .sum_o       (sum_o),
  .invalid_o   (invalid_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .inexact_o   (inexact_o)
);

// File: tb/test_fp32_adder.sv
`timescale 1ns/1ps
module test_fp32_adder;
  localparam logic [31:0] DEF_NAN = 32'h7FC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        valid_o, invalid_o, overflow_o, underflow_o, inexact_o;
  logic [31:0] sum_o;

  int checks = 0;
  int errors = 0;
  logic vld_d = 1'b0;
  bit   mon_on = 1'b0;

  always #4 clk = ~clk;

  fp32_adder i_fp32_adder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .rmode_i(rmode_i), .valid_o(valid_o), .sum_o(sum_o), .invalid_o(invalid_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o), .inexact_o(inexact_o)
  );

  // R1 strobe model, compared every clock
  always @(posedge clk or negedge rst_n)
    if (!rst_n) vld_d <= 1'b0; else vld_d <= valid_i;

  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (valid_o !== vld_d) begin
        errors++;
        $display("FAIL R1: valid_o got %b expected %b", valid_o, vld_d);
      end
    end
  end

  function automatic logic [287:0] to_fixed(input logic [31:0] w);
    logic [287:0] m;
    int e;
    e = (w[30:23] == 0) ? 1 : int'(w[30:23]);
    m = 288'({(w[30:23] != 0), w[22:0]});
    return m << (e - 1);
  endfunction

  // result word followed by flags {invalid, overflow, underflow, inexact}
  function automatic logic [35:0] ref_add(input logic [31:0] a, b, input logic [1:0] rm);
    bit a_nan, b_nan, a_inf, b_inf, a_z, b_z, s, lost, up, to_inf;
    logic [287:0] ma, mb, mag, rem, half;
    logic [24:0] q;
    int p, sh, e;
    a_nan = a[30:23] == 8'hFF && a[22:0] != 0;
    b_nan = b[30:23] == 8'hFF && b[22:0] != 0;
    a_inf = a[30:23] == 8'hFF && a[22:0] == 0;
    b_inf = b[30:23] == 8'hFF && b[22:0] == 0;
    a_z = a[30:0] == 0;
    b_z = b[30:0] == 0;
    if (a_nan && !a[22]) return {a | 32'h0040_0000, 4'b1000};
    if (b_nan && !b[22]) return {b | 32'h0040_0000, 4'b1000};
    if (a_nan) return {a, 4'b0000};
    if (b_nan) return {b, 4'b0000};
    if (a_inf && b_inf) return (a[31] == b[31]) ? {a, 4'b0000} : {DEF_NAN, 4'b1000};
    if (a_inf) return {a, 4'b0000};
    if (b_inf) return {b, 4'b0000};
    if (a_z && b_z) return (a[31] == b[31]) ? {a, 4'b0000} : {rm == 2'd3, 31'd0, 4'b0000};
    if (a_z) return {b, 4'b0000};
    if (b_z) return {a, 4'b0000};
    ma = to_fixed(a);
    mb = to_fixed(b);
    if (a[31] == b[31]) begin mag = ma + mb; s = a[31]; end
    else if (ma >= mb) begin mag = ma - mb; s = a[31]; end
    else begin mag = mb - ma; s = b[31]; end
    if (mag == 0) return {rm == 2'd3, 31'd0, 4'b0000};
    p = 0;
    for (int i = 0; i < 288; i++) if (mag[i]) p = i;
    if (p < 23) return {s, 8'd0, mag[22:0], 4'b0000};
    sh = p - 23;
    q = 25'(mag >> sh);
    rem = mag & ((288'd1 << sh) - 1);
    half = (sh > 0) ? (288'd1 << (sh - 1)) : 288'd0;
    lost = rem != 0;
    case (rm)
      2'd0: up = (sh > 0) && (rem > half || (rem == half && q[0]));
      2'd1: up = 1'b0;
      2'd2: up = lost && !s;
      default: up = lost && s;
    endcase
    q = q + 25'(up);
    e = p - 22;
    if (q[24]) begin q = q >> 1; e++; end
    if (e >= 255) begin
      to_inf = (rm == 2'd0) || (rm == 2'd2 && !s) || (rm == 2'd3 && s);
      return to_inf ? {s, 8'hFF, 23'd0, 4'b0101} : {s, 8'hFE, 23'h7FFFFF, 4'b0101};
    end
    return {s, 8'(e), q[22:0], 3'b000, lost};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h flags %b expected %h flags %b",
               tag, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic issue(input logic [31:0] a, b, input logic [1:0] rm);
    @(negedge clk);
    a_i = a; b_i = b; rmode_i = rm; valid_i = 1'b1;
    @(posedge clk);
    #2;
    valid_i = 1'b0;
  endtask

  // compare against a hand-derived value
  task automatic op_exp(input logic [31:0] a, b, input logic [1:0] rm,
                        input logic [31:0] w, input logic [3:0] fl, input string tag);
    issue(a, b, rm);
    check(tag, {sum_o, invalid_o, overflow_o, underflow_o, inexact_o}, {w, fl});
  endtask

  // compare against the reference model
  task automatic op_ref(input logic [31:0] a, b, input logic [1:0] rm, input string tag);
    logic [35:0] e;
    e = ref_add(a, b, rm);
    issue(a, b, rm);
    check(tag, {sum_o, invalid_o, overflow_o, underflow_o, inexact_o}, e);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    logic [1:0]  rm;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {sum_o, invalid_o, overflow_o, underflow_o, inexact_o}, 36'd0);
    checks++;
    if (valid_o !== 1'b0) begin errors++; $display("FAIL R1: valid_o got %b expected 0", valid_o); end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R2 signaling NaN priority
    op_exp(32'h7F80_0001, 32'h7FA0_0000, 2'd0, 32'h7FC0_0001, 4'b1000, "R2");
    op_exp(32'h7FC0_0005, 32'hFF80_0002, 2'd0, 32'hFFC0_0002, 4'b1000, "R2");
    op_exp(32'h3F80_0000, 32'h7F80_0010, 2'd1, 32'h7FC0_0010, 4'b1000, "R2");
    // R3 quiet NaN pass-through
    op_exp(32'h7FC0_0123, 32'hFFC0_0456, 2'd0, 32'h7FC0_0123, 4'b0000, "R3");
    op_exp(32'h3F80_0000, 32'hFFC0_0456, 2'd2, 32'hFFC0_0456, 4'b0000, "R3");
    // R4 infinities
    op_exp(32'h7F80_0000, 32'hFF80_0000, 2'd0, DEF_NAN, 4'b1000, "R4");
    op_exp(32'hFF80_0000, 32'h3F80_0000, 2'd0, 32'hFF80_0000, 4'b0000, "R4");
    op_exp(32'h7F80_0000, 32'h7F80_0000, 2'd3, 32'h7F80_0000, 4'b0000, "R4");
    op_exp(32'h0000_0001, 32'hFF80_0000, 2'd0, 32'hFF80_0000, 4'b0000, "R4");
    // R5 zeros
    op_exp(32'h0000_0000, 32'h4060_0000, 2'd0, 32'h4060_0000, 4'b0000, "R5");
    op_exp(32'h8000_0000, 32'h8000_0000, 2'd0, 32'h8000_0000, 4'b0000, "R5");
    op_exp(32'h8000_0000, 32'h0000_0003, 2'd3, 32'h0000_0003, 4'b0000, "R5");
    // R6 zero sign by rounding mode
    op_exp(32'h0000_0000, 32'h8000_0000, 2'd0, 32'h0000_0000, 4'b0000, "R6");
    op_exp(32'h0000_0000, 32'h8000_0000, 2'd3, 32'h8000_0000, 4'b0000, "R6");
    op_exp(32'h3FC0_0000, 32'hBFC0_0000, 2'd3, 32'h8000_0000, 4'b0000, "R6");
    op_exp(32'h3FC0_0000, 32'hBFC0_0000, 2'd2, 32'h0000_0000, 4'b0000, "R6");
    // R7 / R11 subnormal sums are exact
    op_exp(32'h0000_0001, 32'h0000_0001, 2'd0, 32'h0000_0002, 4'b0000, "R7");
    op_exp(32'h0040_0000, 32'h0040_0000, 2'd0, 32'h0080_0000, 4'b0000, "R7");
    op_exp(32'h0080_0000, 32'h8000_0001, 2'd2, 32'h007F_FFFF, 4'b0000, "R11");
    // R8 nearest-even ties
    op_exp(32'h3F80_0000, 32'h3380_0000, 2'd0, 32'h3F80_0000, 4'b0001, "R8");
    op_exp(32'h3F80_0001, 32'h3380_0000, 2'd0, 32'h3F80_0002, 4'b0001, "R8");
    op_exp(32'h3F80_0000, 32'h3380_0001, 2'd0, 32'h3F80_0001, 4'b0001, "R8");
    // R9 directed modes
    op_exp(32'h3F80_0000, 32'h3380_0000, 2'd2, 32'h3F80_0001, 4'b0001, "R9");
    op_exp(32'h3F80_0000, 32'h3380_0000, 2'd1, 32'h3F80_0000, 4'b0001, "R9");
    op_exp(32'hBF80_0000, 32'hB380_0000, 2'd3, 32'hBF80_0001, 4'b0001, "R9");
    op_exp(32'hBF80_0000, 32'hB380_0000, 2'd2, 32'hBF80_0000, 4'b0001, "R9");
    // R10 overflow
    op_exp(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd0, 32'h7F80_0000, 4'b0101, "R10");
    op_exp(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'd1, 32'h7F7F_FFFF, 4'b0101, "R10");
    op_exp(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'd2, 32'hFF7F_FFFF, 4'b0101, "R10");
    op_exp(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'd3, 32'hFF80_0000, 4'b0101, "R10");
    // R12 sticky from far-away addend
    op_exp(32'h3F80_0000, 32'h0DA2_4260, 2'd0, 32'h3F80_0000, 4'b0001, "R12");
    op_exp(32'h3F80_0000, 32'h0DA2_4260, 2'd2, 32'h3F80_0001, 4'b0001, "R12");
    op_exp(32'h3F80_0000, 32'h8DA2_4260, 2'd1, 32'h3F7F_FFFF, 4'b0001, "R12");
    op_exp(32'h3F80_0000, 32'h8DA2_4260, 2'd0, 32'h3F80_0000, 4'b0001, "R12");

    // R1 hold: a gap leaves the result registers untouched
    repeat (3) @(negedge clk);
    check("R1", {sum_o, invalid_o, overflow_o, underflow_o, inexact_o},
          {32'h3F80_0000, 4'b0001});

    // random phase, back-to-back issue, exponents kept close
    for (int n = 0; n < 4000; n++) begin
      a  = $urandom;
      rm = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: b = $urandom;
        1: b = {1'($urandom), a[30:23] + 8'($urandom_range(0, 6)) - 8'd3, 23'($urandom)};
        2: b = {~a[31], a[30:23], a[22:0] ^ 23'($urandom_range(0, 15))};
        default: b = {1'($urandom), 8'($urandom_range(0, 2)), 23'($urandom)};
      endcase
      if (n % 2 == 1) op_ref(b, a, rm, (rm == 2'd0) ? "R8" : "R9");
      else            op_ref(a, b, rm, (rm == 2'd0) ? "R8" : "R9");
    end

    @(negedge clk);
    mon_on = 1'b0;
    finish_run();
  end
endmodule